// File: doc/BRIEF.md
# Line Sensor Exposure Controller

This block sits in an FPGA next to a 256-pixel linear image sensor and runs the sensor from the system clock. It produces the sensor clock, places the start pulse that triggers a readout, and drives the shutter line that ends integration after a programmable number of sensor clocks. The sensor keeps integrating in the background while the previous line is read out, so the shutter is the only way to make the exposure shorter than one readout period. For each sensor clock it raises a one-cycle sample strobe for an external ADC. The strobe comes a programmable delay after the clock edge, which leaves the analogue output time to settle. The strobe goes out together with the index of the pixel being presented.

Software supplies a one-cycle start command or holds the continuous-mode input. It also sets the half-period of the sensor clock in system clocks, the strobe delay and the exposure length. Both the half-period and the strobe delay are clamped, so the sensor clock stays at or below 5 MHz at a 250 MHz system clock and the strobe never comes earlier than 200 ns after a rising edge. After the strobe of the last pixel a frame-done flag pulses. In single mode the sensor clock then stops. In continuous mode the next frame follows with no gap.

Top module: `line_exposure_ctrl`

## Requirements
- R1: Each high phase and each low phase of `sclk_o` lasts max(`half_i`, 26) system clocks, so the sensor clock never exceeds 5 MHz at 250 MHz.
- R2: `si_o` changes only while `sclk_o` is low. A frame's SI pulse rises one low phase (the effective half-period) before the rising edge that samples it, and falls on the next falling edge, one high phase after that rising edge.
- R3: A frame consists of exactly 256 rising edges of `sclk_o`, starting with the edge that samples SI. From each rising edge, `pix_o` shows that edge's pixel index, counting 0 for the first pixel and up to 255.
- R4: After every rising edge of `sclk_o`, `strobe_o` is high for exactly one system clock, D clocks later, with D = min(max(`settle_i`, 50), 2·half − 1). `pix_o` carries the index of that edge while the strobe is high.
- R5: When 1 ≤ `exp_i` ≤ 255, `dis_o` rises on the rising edge whose pixel index equals `exp_i`. When `exp_i` is 0 or 256 and above, `dis_o` is never raised. `dis_o` falls only when the next frame's SI rises, and otherwise keeps its level, including while idle.
- R6: `done_o` pulses for one system clock, on the clock after the strobe for pixel index 255.
- R7: In single mode, after the falling edge that follows pixel 255, `sclk_o` and `si_o` stay low until the next start.
- R8: A `start_i` pulse during a frame raises SI on the next falling edge, and the rising edge after it restarts the frame at pixel index 0. No done pulse is given for the cut-short frame.
- R9: With `cont_i` high, the next frame's SI rises on the falling edge after pixel 255, and the low phase at the frame boundary keeps its normal length. With `cont_i` high while idle, a frame starts without `start_i`.
- R10: During reset and right after it, `sclk_o`, `si_o`, `dis_o`, `strobe_o` and `done_o` are low and `pix_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle frame start or restart command |
| cont_i | input | 1 | Continuous mode: frames run back to back |
| half_i | input | 8 | Requested sensor clock half-period in system clocks |
| settle_i | input | 8 | Requested strobe delay after a rising sensor clock edge |
| exp_i | input | 9 | Pixel index at which the shutter closes (0 means never) |
| sclk_o | output | 1 | Sensor clock |
| si_o | output | 1 | Sensor start pulse |
| dis_o | output | 1 | Shutter: high stops integration |
| strobe_o | output | 1 | ADC sample strobe, one system clock |
| pix_o | output | 8 | Index of the pixel on the sensor output |
| done_o | output | 1 | One-cycle pulse after the last pixel's strobe |

## Verification
The bench goes after the clamp boundaries. A half-period request below the floor has to give 26-cycle phases, and a settle request above the period has to be cut to 2·half − 1. A design without these clamps would overclock the sensor, or would fire its strobe after the next clock edge and attach the wrong pixel index. The bench also checks where SI and DIS move. An SI edge that lands next to a rising edge breaks setup or hold, and a shutter that fires one pixel off or never releases gives wrong exposures. It then restarts a frame halfway through and runs frames back to back. A design that gets these wrong reports done for a cut-short frame, or leaves a stretched low phase or a missing SI at the frame boundary.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsx_limits.sv
module lsx_limits #(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned HALF_FLOOR = 26,
    parameter int unsigned MIN_SETTLE = 50
) (
    input  logic [DIV_W-1:0] half_i,
    input  logic [DIV_W-1:0] settle_i,
    output logic [DIV_W-1:0] half_o,
    output logic [DIV_W:0]   dly_o
);
    localparam logic [DIV_W-1:0] FLOOR_V  = DIV_W'(HALF_FLOOR);
    localparam logic [DIV_W:0]   SETTLE_V = (DIV_W+1)'(MIN_SETTLE);

    logic [DIV_W:0] span;
    logic [DIV_W:0] want;

    always_comb begin
        half_o = (half_i < FLOOR_V) ? FLOOR_V : half_i;
        // longest delay that still lands before the next rising edge
        span   = {half_o, 1'b0} - 1'b1;
        want   = ({1'b0, settle_i} < SETTLE_V) ? SETTLE_V : {1'b0, settle_i};
        dly_o  = (want > span) ? span : want;
    end
endmodule

// File: rtl/lsx_phase.sv
module lsx_phase #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic             lvl;
        logic [DIV_W-1:0] cnt;
    } ph_t;

    ph_t ph_d, ph_q;
    logic wrap;

    always_comb begin
        ph_d   = ph_q;
        wrap   = (ph_q.cnt >= (half_i - 1'b1));
        rise_o = en_i && !ph_q.lvl && wrap;
        fall_o = en_i &&  ph_q.lvl && wrap;
        if (!en_i) begin
            ph_d.lvl = 1'b0;
            ph_d.cnt = '0;
        end else if (wrap) begin
            ph_d.lvl = ~ph_q.lvl;
            ph_d.cnt = '0;
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign sclk_o = ph_q.lvl;
endmodule

// File: rtl/lsx_strobe.sv
module lsx_strobe #(
    parameter int unsigned DLY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic             armed;
        logic             stb;
        logic [DLY_W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d     = tm_q;
        tm_d.stb = 1'b0;
        if (tm_q.armed) begin
            if (tm_q.cnt == DLY_W'(1)) begin
                tm_d.stb   = 1'b1;
                tm_d.armed = 1'b0;
            end
            tm_d.cnt = tm_q.cnt - 1'b1;
        end
        if (rise_i) begin
            tm_d.armed = 1'b1;
            tm_d.cnt   = dly_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign strobe_o = tm_q.stb;
endmodule

// File: rtl/lsx_seq.sv
module lsx_seq
    import lsx_pkg::*;
#(
    parameter int unsigned N_PIX = 256,
    parameter int unsigned PIX_W = 8,
    parameter int unsigned EXP_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             stb_i,
    output logic             run_o,
    output logic             si_o,
    output logic             dis_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             done_o
);
    localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(N_PIX - 1);

    typedef struct packed {
        seq_st_e          st;
        logic             si;
        logic             dis;
        logic             pend;
        logic             done;
        logic [PIX_W-1:0] pix;
    } sq_t;

    sq_t sq_d, sq_q;
    logic [PIX_W-1:0] nxt_pix;
    logic             exp_hit;
    logic             last;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = stb_i && (sq_q.pix == LAST_PIX);
        nxt_pix   = sq_q.si ? '0 : sq_q.pix + 1'b1;
        exp_hit   = (exp_i != '0) && ({1'b0, nxt_pix} == exp_i);
        last      = (sq_q.pix == LAST_PIX);
        if (start_i) sq_d.pend = 1'b1;
        unique case (sq_q.st)
            SEQ_IDLE: begin
                if (start_i || cont_i) begin
                    sq_d.st   = SEQ_RUN;
                    sq_d.si   = 1'b1;
                    sq_d.dis  = 1'b0;
                    sq_d.pend = 1'b0;
                end
            end
            SEQ_RUN: begin
                if (rise_i) begin
                    sq_d.pix = nxt_pix;
                    if (exp_hit) sq_d.dis = 1'b1;
                end
                if (fall_i) begin
                    if (sq_q.si) begin
                        sq_d.si = 1'b0;
                    end else if (sq_d.pend || (last && cont_i)) begin
                        sq_d.si   = 1'b1;
                        sq_d.dis  = 1'b0;
                        sq_d.pend = 1'b0;
                    end else if (last) begin
                        sq_d.st = SEQ_IDLE;
                    end
                end
            end
            default: sq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SEQ_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign run_o  = (sq_q.st == SEQ_RUN);
    assign si_o   = sq_q.si;
    assign dis_o  = sq_q.dis;
    assign pix_o  = sq_q.pix;
    assign done_o = sq_q.done;
endmodule

// File: rtl/line_exposure_ctrl.sv
module line_exposure_ctrl #(
    parameter int unsigned N_PIX      = 256,
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned MIN_HALF   = 25,
    parameter int unsigned MIN_SETTLE = 50,
    localparam int unsigned PIX_W     = $clog2(N_PIX),
    localparam int unsigned EXP_W     = PIX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic [DIV_W-1:0] settle_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             sclk_o,
    output logic             si_o,
    output logic             dis_o,
    output logic             strobe_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             done_o
);
    localparam int unsigned DLY_W      = DIV_W + 1;
    localparam int unsigned HALF_FLOOR = lsx_pkg::umax(MIN_HALF, (MIN_SETTLE + 2) / 2);

    logic [DIV_W-1:0] half_eff;
    logic [DLY_W-1:0] dly_eff;
    logic             run, rise, fall;

    lsx_limits #(.DIV_W(DIV_W), .HALF_FLOOR(HALF_FLOOR), .MIN_SETTLE(MIN_SETTLE)) u_limits (
        .half_i  (half_i),
        .settle_i(settle_i),
        .half_o  (half_eff),
        .dly_o   (dly_eff)
    );

    lsx_phase #(.DIV_W(DIV_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (run),
        .half_i(half_eff),
        .sclk_o(sclk_o),
        .rise_o(rise),
        .fall_o(fall)
    );

    lsx_strobe #(.DLY_W(DLY_W)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .dly_i   (dly_eff),
        .strobe_o(strobe_o)
    );

    lsx_seq #(.N_PIX(N_PIX), .PIX_W(PIX_W), .EXP_W(EXP_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .cont_i (cont_i),
        .exp_i  (exp_i),
        .rise_i (rise),
        .fall_i (fall),
        .stb_i  (strobe_o),
        .run_o  (run),
        .si_o   (si_o),
        .dis_o  (dis_o),
        .pix_o  (pix_o),
        .done_o (done_o)
    );
endmodule

// File: rtl/lsx_chk.sv
module lsx_chk #(
    parameter int unsigned N_PIX      = 256,
    parameter int unsigned PIX_W      = 8,
    parameter int unsigned MIN_HALF   = 25,
    parameter int unsigned MIN_SETTLE = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_o,
    input logic             si_o,
    input logic             dis_o,
    input logic             strobe_o,
    input logic [PIX_W-1:0] pix_o,
    input logic             done_o
);
    localparam int unsigned HALF_FLOOR = lsx_pkg::umax(MIN_HALF, (MIN_SETTLE + 2) / 2);
    localparam logic [15:0] FLOOR_M1   = 16'(HALF_FLOOR - 1);

    logic        sclk_prev;
    logic [15:0] stay_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            stay_cnt  <= '0;
        end else begin
            sclk_prev <= sclk_o;
            if (sclk_o != sclk_prev) stay_cnt <= '0;
            else if (stay_cnt != 16'hFFFF) stay_cnt <= stay_cnt + 1'b1;
        end
    end

    // R1
    min_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o != sclk_prev) |-> (stay_cnt >= FLOOR_M1));

    // R2
    si_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(si_o) |-> !sclk_o);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(strobe_o) && ($past(pix_o) == PIX_W'(N_PIX - 1))));

    // R5
    dis_rise_on_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_o) |-> $rose(sclk_o));

    // R5
    dis_fall_on_si_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_o) |-> $rose(si_o));
endmodule

bind line_exposure_ctrl lsx_chk #(
    .N_PIX     (N_PIX),
    .PIX_W     (PIX_W),
    .MIN_HALF  (MIN_HALF),
    .MIN_SETTLE(MIN_SETTLE)
) u_lsx_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .si_o    (si_o),
    .dis_o   (dis_o),
    .strobe_o(strobe_o),
    .pix_o   (pix_o),
    .done_o  (done_o)
);

// File: tb/line_exposure_ctrl_bench.sv
`timescale 1ns/1ps
module line_exposure_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, cont_i = 1'b0;
    logic [7:0] half_i = 8'd26, settle_i = 8'd50;
    logic [8:0] exp_i = 9'd0;
    logic       sclk_o, si_o, dis_o, strobe_o, done_o;
    logic [7:0] pix_o;

    always #2 clk = ~clk;

    line_exposure_ctrl u_line_exposure_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .half_i(half_i), .settle_i(settle_i), .exp_i(exp_i),
        .sclk_o(sclk_o), .si_o(si_o), .dis_o(dis_o), .strobe_o(strobe_o),
        .pix_o(pix_o), .done_o(done_o)
    );

    int n_chk = 0, n_bad = 0;

    // monitor state, sampled on the falling system clock edge
    int cyc = 0;
    logic sclk_p = 1'b0, si_p = 1'b0, dis_p = 1'b0;
    int rise_cyc, si_up_cyc, lo_start, hi_start, last_stb_cyc, last_stb_pix;
    int hi_min, hi_max, lo_min, lo_max, dly_min, dly_max;
    int setup_w, hold_w, mpix, pix_err, rises, rises_si, si_rises;
    int strobes, dones, done_gap, done_pix, done_rises, dis_rises, dis_pix, dis_err;

    task automatic clear_mon();
        hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
        dly_min = 9999; dly_max = 0; lo_start = -1; hi_start = -1;
        setup_w = -1; hold_w = -1; pix_err = 0; rises = 0; rises_si = 0; si_rises = 0;
        strobes = 0; dones = 0; done_gap = -1; done_pix = -1; done_rises = -1;
        dis_rises = 0; dis_pix = -1; dis_err = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (si_o && !si_p) si_up_cyc = cyc;
            if (sclk_o && !sclk_p) begin
                if (lo_start >= 0) begin
                    lo_min = (cyc - lo_start < lo_min) ? cyc - lo_start : lo_min;
                    lo_max = (cyc - lo_start > lo_max) ? cyc - lo_start : lo_max;
                end
                hi_start = cyc; rise_cyc = cyc; rises++;
                if (si_o) begin
                    mpix = 0; rises_si = 1; si_rises++; setup_w = cyc - si_up_cyc;
                end else begin
                    mpix++; rises_si++;
                end
            end
            if (!sclk_o && sclk_p) begin
                if (hi_start >= 0) begin
                    hi_min = (cyc - hi_start < hi_min) ? cyc - hi_start : hi_min;
                    hi_max = (cyc - hi_start > hi_max) ? cyc - hi_start : hi_max;
                end
                lo_start = cyc;
            end
            if (!si_o && si_p) hold_w = cyc - rise_cyc;
            if (strobe_o) begin
                strobes++;
                dly_min = (cyc - rise_cyc < dly_min) ? cyc - rise_cyc : dly_min;
                dly_max = (cyc - rise_cyc > dly_max) ? cyc - rise_cyc : dly_max;
                if (int'(pix_o) != mpix) pix_err++;
                last_stb_cyc = cyc; last_stb_pix = int'(pix_o);
            end
            if (done_o) begin
                dones++; done_gap = cyc - last_stb_cyc;
                done_pix = last_stb_pix; done_rises = rises_si;
            end
            if (dis_o && !dis_p) begin dis_rises++; dis_pix = int'(pix_o); end
            if (!dis_o && dis_p && !(si_o && !si_p)) dis_err++;
        end
        sclk_p = sclk_o; si_p = si_o; dis_p = dis_o;
    end

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=complete");
        finish_up();
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic wait_dones(input int n);
        while (dones < n) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic idle_check(input string tag);
        int r0;
        r0 = rises;
        repeat (300) @(posedge clk);
        #1;
        check({tag, " R7 no clock edges while idle"}, rises - r0, 0);
        check({tag, " R7 sclk low while idle"}, int'(sclk_o), 0);
        check({tag, " R7 si low while idle"}, int'(si_o), 0);
    endtask

    // half_in, settle_in, exp_in, want_half, want_dly, want_dis_pix (-1: never)
    localparam int VT [4][6] = '{
        '{26,  50, 100, 26, 50, 100},
        '{ 5,  10,   0, 26, 50,  -1},
        '{40,  60, 255, 40, 60, 255},
        '{30, 200,   1, 30, 59,   1}
    };

    initial begin
        clear_mon();
        repeat (5) @(posedge clk);
        #1;
        check("R10 sclk in reset", int'(sclk_o), 0);
        check("R10 si in reset", int'(si_o), 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check("R10 dis after reset", int'(dis_o), 0);
        check("R10 strobe after reset", int'(strobe_o), 0);
        check("R10 done after reset", int'(done_o), 0);
        check("R10 pix after reset", int'(pix_o), 0);
        check("R10 sclk after reset", int'(sclk_o), 0);

        for (int i = 0; i < 4; i++) begin
            half_i = 8'(VT[i][0]); settle_i = 8'(VT[i][1]); exp_i = 9'(VT[i][2]);
            clear_mon();
            pulse_start();
            wait_dones(1);
            check("R1 high phase min", hi_min, VT[i][3]);
            check("R1 high phase max", hi_max, VT[i][3]);
            check("R1 low phase min", lo_min, VT[i][3]);
            check("R2 SI setup cycles", setup_w, VT[i][3]);
            check("R2 SI hold cycles", hold_w, VT[i][3]);
            check("R3 rises per frame", done_rises, 256);
            check("R3 pixel index order errors", pix_err, 0);
            check("R4 strobe delay min", dly_min, VT[i][4]);
            check("R4 strobe delay max", dly_max, VT[i][4]);
            check("R4 strobes per frame", strobes, 256);
            check("R6 done count", dones, 1);
            check("R6 done gap after strobe", done_gap, 1);
            check("R6 done follows pixel 255", done_pix, 255);
            check("R5 shutter rises", dis_rises, (VT[i][5] < 0) ? 0 : 1);
            if (VT[i][5] >= 0) begin
                check("R5 shutter pixel", dis_pix, VT[i][5]);
                check("R5 shutter held high in idle", int'(dis_o), 1);
            end else begin
                check("R5 shutter low with exp 0", int'(dis_o), 0);
            end
            check("R5 shutter fell only at SI", dis_err, 0);
            idle_check("row");
        end

        // R8: restart in the middle of a frame
        half_i = 8'd26; settle_i = 8'd50; exp_i = 9'd0;
        clear_mon();
        pulse_start();
        while (strobes < 40) @(posedge clk);
        pulse_start();
        wait_dones(1);
        repeat (100) @(posedge clk);
        check("R8 SI pulses (start + restart)", si_rises, 2);
        check("R8 single done after restart", dones, 1);
        check("R8 rises from restart to done", done_rises, 256);
        check("R8 pixel order after restart", pix_err, 0);
        check("R8 done follows pixel 255", done_pix, 255);
        idle_check("restart");

        // R9: continuous mode, start from idle by cont_i alone
        clear_mon();
        @(posedge clk); #1 cont_i = 1'b1;
        while (dones < 2) @(posedge clk);
        #1 cont_i = 1'b0;
        wait_dones(3);
        check("R9 frames completed", dones, 3);
        check("R9 SI pulses", si_rises, 3);
        check("R9 low phase min across boundary", lo_min, 26);
        check("R9 low phase max across boundary", lo_max, 26);
        check("R9 pixel order", pix_err, 0);
        check("R9 strobes", strobes, 768);
        idle_check("cont");

        finish_up();
    end
endmodule